// File: doc/BRIEF.md
# Source-Synchronous Serial Input Stage

This block takes a serial bitstream that arrives with its own bit clock and hands the bits to the system clock domain as a plain bit stream with a one-cycle valid strobe. The external clock samples the data line on an edge chosen by software. The sampled bit then passes through a programmable delay line in the external domain, crosses into the system domain through a small asynchronous FIFO, and can be run through a self-synchronizing telemetry randomizer before it leaves the block.

Software controls the stage through a minimal AXI4-Lite slave with two words: a control word and a status word. The control fields are meant to be changed while the stage is disabled. Clearing the enable bit empties the crossing FIFO, clears the delay line and loads the randomizer with all ones. The following enable therefore starts from a known state. The status word holds a sticky flag that reports a bit lost to a full FIFO.

Top module: `serial_in_stage`

## Requirements
- R1: Control bit 2 picks the sampling edge of the external clock: 0 samples on the rising edge and 1 samples on the falling edge.
- R2: Control bits [7:4] hold a delay d from 0 to 15 external-clock cycles. After an enable, the output stream starts with exactly d zero bits, followed by the sampled bits in order.
- R3: Sampled bits come out on `bit_out`, qualified by a one-cycle `bit_valid` pulse in the system clock domain. Bits are neither lost nor repeated while the external bit rate is below the system clock rate.
- R4: With control bit 1 set, the randomizer is active. Each output bit equals the input bit XOR stages 14 and 15 of a 15-stage register. The output bit is shifted back into the register (polynomial x^15 + x^14 + 1), and the register holds all ones at every enable.
- R5: With control bit 1 clear, each output bit equals the bit read from the FIFO.
- R6: Control bit 0 enables the stage. After it is cleared, `bit_valid` stays low, and the FIFO and delay line are emptied, so the next enable shows no stale bits.
- R7: A bit that arrives while the FIFO is full sets status bit 0 at word offset 0x4. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: The control word at offset 0x0 reads back its fields, with bit 3 and bits [31:8] reading as zero. Reads of unmapped offsets return zero. Every response is OKAY. The write response is valid on the clock edge after the write is accepted, and read data is valid on the clock edge after the read address is accepted.
- R9: After reset the control and status words read zero and `bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Bit clock that arrives with the data |
| ext_data | input | 1 | Serial data line |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes (byte 0 carries all fields) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| bit_out | output | 1 | Received bit |
| bit_valid | output | 1 | One-cycle strobe for `bit_out` |

## Verification
Register results have fixed latencies. A write response appears one system-clock edge after the address and data are accepted, and read data one edge after the read address is accepted. The bench samples both on the following falling clock edge. The bit stream has no fixed latency, because of the synchronizers and the pointer crossing. The bench therefore records every `bit_valid` bit and compares each bit by its position counted from the enable write, not by cycle count. That position is exact: the first d bits are the cleared delay line, and the randomizer adds one register stage after each FIFO pop. The effect of disabling is checked after a settling margin of several system cycles, once the clear has had time to reach the output.

// File: rtl/sis_pkg.sv
`timescale 1ns/1ps
package sis_pkg;

    localparam int AXI_DW  = 32;
    localparam int DLY_W   = 4;
    localparam int SCR_LEN = 15;

    // Word indices (address bits [3:2]).
    localparam logic [1:0] WORD_CTRL = 2'd0;
    localparam logic [1:0] WORD_STAT = 2'd1;

    typedef struct packed {
        logic [DLY_W-1:0] delay;
        logic             fall_edge;
        logic             scr_en;
        logic             enable;
    } sis_cfg_t;

    function automatic sis_cfg_t cfg_from_byte(input logic [7:0] b);
        sis_cfg_t c;
        c.delay     = b[7:4];
        c.fall_edge = b[2];
        c.scr_en    = b[1];
        c.enable    = b[0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input sis_cfg_t c);
        return {c.delay, 1'b0, c.fall_edge, c.scr_en, c.enable};
    endfunction

    // Self-synchronizing mix: input XOR the two oldest stages.
    function automatic logic scr_mix(input logic [SCR_LEN-1:0] st, input logic b);
        return b ^ st[SCR_LEN-2] ^ st[SCR_LEN-1];
    endfunction

endpackage

// File: rtl/sis_capture.sv
`timescale 1ns/1ps
module sis_capture
    import sis_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          ext_clk,
    input  logic          clear,
    input  logic          din,
    input  logic          fall_sel,
    input  logic [DW-1:0] tap,
    output logic          wr_vld,
    output logic          wr_bit
);
    localparam int TAPS = 1 << DW;

    logic            neg_q;
    logic            smp;
    logic            smp_vld;
    logic [TAPS-2:0] dline;
    logic [TAPS-1:0] taps_v;

    always_ff @(negedge ext_clk) begin
        neg_q <= din;
    end

    always_ff @(posedge ext_clk) begin
        if (clear) begin
            smp     <= 1'b0;
            smp_vld <= 1'b0;
            dline   <= '0;
        end else begin
            smp     <= fall_sel ? neg_q : din;
            smp_vld <= 1'b1;
            if (smp_vld) begin
                dline <= {dline[TAPS-3:0], smp};
            end
        end
    end

    assign taps_v = {dline, smp};
    assign wr_bit = taps_v[tap];
    assign wr_vld = smp_vld;

    // R2
    delay_one_chk: assert property (@(posedge ext_clk) disable iff (clear)
        (tap == DW'(1) && $stable(tap) && $past(smp_vld)) |-> (wr_bit == $past(smp)));

endmodule

// File: rtl/sis_afifo.sv
`timescale 1ns/1ps
module sis_afifo #(
    parameter int DEPTH = 16
) (
    input  logic wclk,
    input  logic wrst,
    input  logic wclear,
    input  logic we,
    input  logic wbit,
    input  logic rclk,
    input  logic rrst,
    input  logic rclear,
    output logic pop,
    output logic rbit,
    output logic ovf_evt
);
    localparam int AW = $clog2(DEPTH);

    logic          mem [DEPTH];
    logic [AW:0]   wbin, wgray, wnext;
    logic [AW:0]   rbin, rgray, rnext;
    logic [AW:0]   rs1, rs2, ws1, ws2;
    logic          full, empty, ovf_tgl;
    logic [2:0]    osync;

    // ---------------- write side (external clock) ----------------
    assign wnext = wbin + 1'b1;
    assign full  = (wgray == {~rs2[AW:AW-1], rs2[AW-2:0]});

    always_ff @(posedge wclk) begin
        if (we && !full) begin
            mem[wbin[AW-1:0]] <= wbit;
        end
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            rs1     <= '0;
            rs2     <= '0;
            ovf_tgl <= 1'b0;
        end else begin
            rs1 <= rgray;
            rs2 <= rs1;
            if (we && full && !wclear) begin
                ovf_tgl <= ~ovf_tgl;
            end
        end
        if (wrst || wclear) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we && !full) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    // ---------------- read side (system clock) ----------------
    assign rnext = rbin + 1'b1;
    assign empty = (rgray == ws2);
    assign pop   = !empty && !rclear;
    assign rbit  = mem[rbin[AW-1:0]];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            ws1   <= '0;
            ws2   <= '0;
            osync <= '0;
        end else begin
            ws1   <= wgray;
            ws2   <= ws1;
            osync <= {osync[1:0], ovf_tgl};
        end
        if (rrst || rclear) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rnext;
            rgray <= rnext ^ (rnext >> 1);
        end
    end

    assign ovf_evt = osync[2] ^ osync[1];

    // R3
    rd_gray_step_chk: assert property (@(posedge rclk) disable iff (rrst || rclear)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R3
    wr_gray_step_chk: assert property (@(posedge wclk) disable iff (wrst || wclear)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/sis_scrambler.sv
`timescale 1ns/1ps
module sis_scrambler
    import sis_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  logic scr_en,
    input  logic in_vld,
    input  logic in_bit,
    output logic out_vld,
    output logic out_bit
);
    logic [SCR_LEN-1:0] st;
    logic               mixed;

    assign mixed = scr_en ? scr_mix(st, in_bit) : in_bit;

    always_ff @(posedge clk) begin
        if (clear) begin
            st      <= '1;
            out_vld <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_bit <= mixed;
                if (scr_en) begin
                    st <= {st[SCR_LEN-2:0], mixed};
                end
            end
        end
    end

    // R5
    passthru_chk: assert property (@(posedge clk) disable iff (clear)
        (in_vld && !scr_en) |=> (out_vld && out_bit == $past(in_bit)));

    // R6
    quiet_chk: assert property (@(posedge clk)
        clear |=> !out_vld);

endmodule

// File: rtl/sis_regs.sv
`timescale 1ns/1ps
module sis_regs
    import sis_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [AXI_DW-1:0] wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [AXI_DW-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic              ovf_evt,
    output sis_cfg_t          cfg
);
    logic       wr_go, rd_go, ovf_q, ovf_clr;
    logic [1:0] wsel, rsel;
    logic       unused_bits;

    assign wr_go   = awvalid && wvalid && !bvalid;
    assign rd_go   = arvalid && !rvalid;
    assign awready = wr_go;
    assign wready  = wr_go;
    assign arready = rd_go;
    assign bresp   = 2'b00;
    assign rresp   = 2'b00;
    assign wsel    = awaddr[3:2];
    assign rsel    = araddr[3:2];
    assign ovf_clr = wr_go && wstrb[0] && (wsel == WORD_STAT) && wdata[0];
    assign unused_bits = ^{awaddr, araddr, wdata[AXI_DW-1:8], wstrb[3:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            ovf_q  <= 1'b0;
            bvalid <= 1'b0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            if (wr_go) begin
                bvalid <= 1'b1;
            end else if (bready) begin
                bvalid <= 1'b0;
            end
            if (wr_go && wstrb[0] && (wsel == WORD_CTRL)) begin
                cfg <= cfg_from_byte(wdata[7:0]);
            end
            if (ovf_evt) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
            if (rd_go) begin
                rvalid <= 1'b1;
                case (rsel)
                    WORD_CTRL: rdata <= {{(AXI_DW-8){1'b0}}, cfg_to_byte(cfg)};
                    WORD_STAT: rdata <= {{(AXI_DW-1){1'b0}}, ovf_q};
                    default:   rdata <= '0;
                endcase
            end else if (rready) begin
                rvalid <= 1'b0;
            end
        end
    end

    // R8
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);

    // R8
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (arvalid && arready) |=> rvalid);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q);

endmodule

// File: rtl/serial_in_stage.sv
`timescale 1ns/1ps
module serial_in_stage
    import sis_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk,
    input  logic              ext_data,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [AXI_DW-1:0] s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [AXI_DW-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              bit_out,
    output logic              bit_valid
);
    sis_cfg_t   cfg;
    logic [1:0] rst_sync, en_sync;
    logic       rst_x, wclear, rclear;
    logic       wr_vld, wr_bit, pop, rd_bit, ovf_evt;

    // Reset and enable brought into the external clock domain.
    always_ff @(posedge ext_clk) begin
        rst_sync <= {rst_sync[0], rst};
        if (rst_x) begin
            en_sync <= 2'b00;
        end else begin
            en_sync <= {en_sync[0], cfg.enable};
        end
    end

    assign rst_x  = rst_sync[1];
    assign wclear = rst_x || !en_sync[1];
    assign rclear = rst || !cfg.enable;

    sis_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .ovf_evt (ovf_evt),
        .cfg     (cfg)
    );

    sis_capture #(.DW(DLY_W)) i_capture (
        .ext_clk  (ext_clk),
        .clear    (wclear),
        .din      (ext_data),
        .fall_sel (cfg.fall_edge),
        .tap      (cfg.delay),
        .wr_vld   (wr_vld),
        .wr_bit   (wr_bit)
    );

    sis_afifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .wclk    (ext_clk),
        .wrst    (rst_x),
        .wclear  (wclear),
        .we      (wr_vld),
        .wbit    (wr_bit),
        .rclk    (clk),
        .rrst    (rst),
        .rclear  (rclear),
        .pop     (pop),
        .rbit    (rd_bit),
        .ovf_evt (ovf_evt)
    );

    sis_scrambler i_scr (
        .clk     (clk),
        .clear   (rclear),
        .scr_en  (cfg.scr_en),
        .in_vld  (pop),
        .in_bit  (rd_bit),
        .out_vld (bit_valid),
        .out_bit (bit_out)
    );

endmodule

// File: tb/test_serial_in_stage.sv
`timescale 1ns/1ps
module test_serial_in_stage;

    logic        clk = 1'b0, rst = 1'b1, ext_clk = 1'b0, ext_data = 1'b0;
    logic [3:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        bit_out, bit_valid;

    real q = 4.0;
    int  checks = 0, errors = 0;
    logic cap [0:4095];
    int  ncap = 0;
    logic        last_bvalid;
    logic        last_rvalid;

    serial_in_stage i_serial_in_stage (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .ext_data(ext_data),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    always #2 clk = ~clk;

    // Data is high around each falling edge and low around each rising edge.
    initial forever begin
        ext_clk = 1'b1; #(q);
        ext_data = 1'b1; #(q);
        ext_clk = 1'b0; #(q);
        ext_data = 1'b0; #(q);
    end

    always @(negedge clk) begin
        if (bit_valid && ncap < 4096) begin
            cap[ncap] = bit_out;
            ncap = ncap + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        awaddr = a; wdata = d; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        while (!awready) @(negedge clk);
        @(posedge clk); #1;
        awvalid = 1'b0; wvalid = 1'b0;
        @(negedge clk);
        last_bvalid = bvalid;
    endtask

    task automatic axi_rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        araddr = a; arvalid = 1'b1;
        @(negedge clk);
        while (!arready) @(negedge clk);
        @(posedge clk); #1;
        arvalid = 1'b0;
        @(negedge clk);
        last_rvalid = rvalid;
        d = rdata;
    endtask

    // One enable period; compares n output bits against the computed stream.
    task automatic run(input string req, input int d, input bit fall, input bit rnd, input int n);
        logic [31:0] cw;
        logic [14:0] st;
        logic        e_in, e_out;
        int          base, mism;
        cw = {24'd0, 4'(d), 1'b0, fall, rnd, 1'b0};
        axi_wr(4'h0, cw);
        repeat (60) @(posedge clk);
        base = ncap;
        axi_wr(4'h0, cw | 32'd1);
        while (ncap < base + n) @(posedge clk);
        st = '1;
        mism = 0;
        for (int i = 0; i < n; i++) begin
            e_in  = fall && (i >= d);
            e_out = rnd ? (e_in ^ st[13] ^ st[14]) : e_in;
            if (rnd) st = {st[13:0], e_out};
            if (cap[base + i] !== e_out) mism++;
        end
        chk(req, mism, 0, $sformatf("bit mismatches d=%0d fall=%0d rnd=%0d", d, fall, rnd));
        axi_wr(4'h0, cw);
    endtask

    task automatic main_seq();
        logic [31:0] rd;
        int          cnt;
        repeat (10) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9", int'(bit_valid), 0, "bit_valid after reset");
        axi_rd(4'h0, rd);
        chk("R9", int'(rd), 0, "control after reset");
        axi_rd(4'h4, rd);
        chk("R9", int'(rd), 0, "status after reset");
        // R8 register access
        axi_wr(4'h0, 32'h0000_00F6);
        chk("R8", int'(last_bvalid), 1, "bvalid one edge after accept");
        chk("R8", int'(bresp), 0, "bresp OKAY");
        axi_rd(4'h0, rd);
        chk("R8", int'(last_rvalid), 1, "rvalid one edge after accept");
        chk("R8", int'(rd), 32'hF6, "control readback");
        axi_wr(4'h0, 32'hFFFF_FFFE);
        axi_rd(4'h0, rd);
        chk("R8", int'(rd), 32'hF6, "reserved bits read zero");
        axi_rd(4'h8, rd);
        chk("R8", int'(rd), 0, "unmapped read");
        chk("R8", int'(rresp), 0, "rresp OKAY");
        axi_wr(4'h0, 32'h0);
        // R2 delay sweep, falling-edge capture, randomizer off (R1, R3, R5)
        for (int d = 0; d < 16; d++) run("R2", d, 1'b1, 1'b0, 40);
        // R1 rising-edge capture sees the low half of the data pulse
        run("R1", 2, 1'b0, 1'b0, 40);
        // R4 randomizer on
        run("R4", 0, 1'b1, 1'b1, 48);
        run("R4", 5, 1'b1, 1'b1, 48);
        run("R4", 15, 1'b1, 1'b1, 48);
        // R3 no spurious overflow at normal rate
        axi_rd(4'h4, rd);
        chk("R3", int'(rd), 0, "no overflow at normal rate");
        // R7 overflow with a fast bit clock
        axi_wr(4'h0, 32'h0000_0004);
        repeat (60) @(posedge clk);
        axi_wr(4'h0, 32'h0000_0005);
        q = 0.5;
        repeat (100) @(posedge clk);
        q = 4.0;
        axi_wr(4'h0, 32'h0000_0004);
        repeat (40) @(posedge clk);
        axi_rd(4'h4, rd);
        chk("R7", int'(rd), 1, "overflow flag set");
        axi_wr(4'h4, 32'h0);
        axi_rd(4'h4, rd);
        chk("R7", int'(rd), 1, "write 0 keeps flag");
        axi_wr(4'h4, 32'h1);
        axi_rd(4'h4, rd);
        chk("R7", int'(rd), 0, "write 1 clears flag");
        // R6 disabled stage stays quiet, then restarts clean
        repeat (4) @(posedge clk);
        cnt = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (bit_valid) cnt++;
        end
        chk("R6", cnt, 0, "bit_valid while disabled");
        run("R6", 3, 1'b1, 1'b0, 40);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule